// File: doc/BRIEF.md
# Asymmetric Dual-Issue Pairing Unit

This unit sits at the head of an in-order instruction queue and looks at the two oldest decoded entries every clock cycle. It decides whether those two entries can leave together, one to each of two integer pipes with unequal abilities. Pipe A accepts every integer class. Pipe B accepts only plain arithmetic and register moves. The older entry always goes to pipe A. The younger entry joins it on pipe B only when the two entries are independent and the younger one fits pipe B. If they cannot pair, the older entry leaves alone, and the younger entry becomes the older slot of the next pair.

The pairing tests are purely combinational from the slot inputs. The issue strobes and the consumed count are registered, so a decision made on the slot values present at a rising edge appears on the outputs just after that edge and holds for one cycle. The queue uses the consumed count to pop zero, one or two entries.

Top module: `dual_issue_pair`

## Requirements
- R1: While reset is asserted (active low), both issue strobes and the consumed count are zero.
- R2: When the downstream ready input is low at a rising edge, neither pipe issues and the consumed count is zero, whatever the slots hold.
- R3: When ready is high and the older slot is valid, the older entry issues on pipe A for every class code 0 to 7.
- R4: When ready is high, the older slot is valid and the younger slot is invalid, only pipe A issues and the count is 1.
- R5: When ready is high, both slots are valid, the younger class is 0 (simple arithmetic) or 1 (move) and no conflict below applies, both pipes issue and the count is 2.
- R6: A younger entry with class 2 (shift), 3 (multiply), 4 (branch), 5 (complex) or the unused codes 6 and 7 never issues on pipe B; the older one issues alone with count 1.
- R7: Read-after-write: if the older entry writes (write enable high) a nonzero register that equals either younger source index, only the older one issues.
- R8: Write-after-write: if both entries write the same nonzero register, only the older one issues.
- R9: Register index 0 never creates a conflict, and an older entry with write enable low creates no read-after-write conflict.
- R10: If both unit-use tags are equal and nonzero, only the older entry issues; tag 0 means no shared resource and never conflicts.
- R11: Outputs change only at rising edges: they reflect the slot and ready values sampled at the previous edge and ignore input changes between edges.
- R12: When the older slot is invalid, nothing issues and the count is zero, even if the younger slot is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ready_i | input | 1 | Downstream pipes can accept this cycle |
| s0_valid_i | input | 1 | Older slot holds an entry |
| s0_class_i | input | 3 | Older entry class code |
| s0_dst_i | input | REG_W | Older destination register index |
| s0_wen_i | input | 1 | Older entry writes its destination |
| s0_unit_i | input | UNIT_W | Older entry unit-use tag |
| s1_valid_i | input | 1 | Younger slot holds an entry |
| s1_class_i | input | 3 | Younger entry class code |
| s1_dst_i | input | REG_W | Younger destination register index |
| s1_wen_i | input | 1 | Younger entry writes its destination |
| s1_src_a_i | input | REG_W | Younger first source register index |
| s1_src_b_i | input | REG_W | Younger second source register index |
| s1_unit_i | input | UNIT_W | Younger entry unit-use tag |
| pipe_a_issue_o | output | 1 | Older entry issued on pipe A |
| pipe_b_issue_o | output | 1 | Younger entry issued on pipe B |
| consumed_o | output | 2 | Entries taken from the queue (0, 1 or 2) |

## Verification
The functions that meet in one cycle are the stall from ready and the pairing decision, and likewise several pairing vetoes at once. A pair that would otherwise issue together is held with ready low and must yield zero, then the same slots are presented with ready high and must yield two. Pairs that carry a read-after-write hit together with a unit clash, or a class veto together with a write-after-write hit, must still leave exactly one entry, judged at the strobes and the count one edge later.

// File: rtl/issue_pair_pkg.sv
package issue_pair_pkg;

    localparam int CLS_W   = 3;
    localparam int NUM_SRC = 2;

    typedef enum logic [CLS_W-1:0] {
        CLS_ALU   = 3'd0,
        CLS_MOVE  = 3'd1,
        CLS_SHIFT = 3'd2,
        CLS_MUL   = 3'd3,
        CLS_BR    = 3'd4,
        CLS_CPLX  = 3'd5,
        CLS_RSV6  = 3'd6,
        CLS_RSV7  = 3'd7
    } iclass_e;

    // Bit n set: class code n is accepted by the restricted pipe
    localparam logic [(1<<CLS_W)-1:0] PIPE_B_MASK = 8'b0000_0011;

    typedef struct packed {
        logic       a;
        logic       b;
        logic [1:0] cnt;
    } issue_t;

endpackage

// File: rtl/pair_class_filter.sv
module pair_class_filter
    import issue_pair_pkg::*;
#(
    parameter logic [(1<<CLS_W)-1:0] ACCEPT_MASK = PIPE_B_MASK
) (
    input  logic [CLS_W-1:0] cls_i,
    output logic             fits_o
);
    localparam int NCODES = 1 << CLS_W;

    logic [NCODES-1:0] hit;

    generate
        for (genvar c = 0; c < NCODES; c++) begin : g_code
            assign hit[c] = ACCEPT_MASK[c] && (cls_i == CLS_W'(c));
        end
    endgenerate

    always_comb begin
        fits_o = |hit;
    end

    // R6
    fits_only_low_codes_chk: assert final (!(fits_o && (cls_i > CLS_W'(1))));

endmodule

// File: rtl/pair_hazard_chk.sv
module pair_hazard_chk
    import issue_pair_pkg::*;
#(
    parameter int REG_W  = 5,
    parameter int UNIT_W = 2
) (
    input  logic [REG_W-1:0]              old_dst_i,
    input  logic                          old_wen_i,
    input  logic [UNIT_W-1:0]             old_unit_i,
    input  logic [NUM_SRC-1:0][REG_W-1:0] yng_src_i,
    input  logic [REG_W-1:0]              yng_dst_i,
    input  logic                          yng_wen_i,
    input  logic [UNIT_W-1:0]             yng_unit_i,
    output logic                          raw_o,
    output logic                          waw_o,
    output logic                          unit_o
);
    logic              old_writes;
    logic [NUM_SRC-1:0] src_hit;

    assign old_writes = old_wen_i && (old_dst_i != '0);

    generate
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
            assign src_hit[s] = (yng_src_i[s] == old_dst_i);
        end
    endgenerate

    always_comb begin
        raw_o  = old_writes && (|src_hit);
        waw_o  = old_writes && yng_wen_i && (yng_dst_i == old_dst_i);
        unit_o = (old_unit_i != '0) && (old_unit_i == yng_unit_i);
    end

    // R9
    zero_reg_quiet_chk: assert final (!((old_dst_i == '0) && (raw_o || waw_o)));
    // R10
    zero_tag_quiet_chk: assert final (!((old_unit_i == '0) && unit_o));

endmodule

// File: rtl/dual_issue_pair.sv
module dual_issue_pair
    import issue_pair_pkg::*;
#(
    parameter int REG_W  = 5,
    parameter int UNIT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ready_i,
    input  logic              s0_valid_i,
    input  logic [2:0]        s0_class_i,
    input  logic [REG_W-1:0]  s0_dst_i,
    input  logic              s0_wen_i,
    input  logic [UNIT_W-1:0] s0_unit_i,
    input  logic              s1_valid_i,
    input  logic [2:0]        s1_class_i,
    input  logic [REG_W-1:0]  s1_dst_i,
    input  logic              s1_wen_i,
    input  logic [REG_W-1:0]  s1_src_a_i,
    input  logic [REG_W-1:0]  s1_src_b_i,
    input  logic [UNIT_W-1:0] s1_unit_i,
    output logic              pipe_a_issue_o,
    output logic              pipe_b_issue_o,
    output logic [1:0]        consumed_o
);
    logic [NUM_SRC-1:0][REG_W-1:0] yng_src;
    logic   yng_fits;
    logic   raw_hit;
    logic   waw_hit;
    logic   unit_hit;
    logic   pair_ok;
    issue_t iss_d;
    issue_t iss_q;

    assign yng_src[0] = s1_src_a_i;
    assign yng_src[1] = s1_src_b_i;

    pair_class_filter #(
        .ACCEPT_MASK (PIPE_B_MASK)
    ) u_cls (
        .cls_i  (s1_class_i),
        .fits_o (yng_fits)
    );

    pair_hazard_chk #(
        .REG_W  (REG_W),
        .UNIT_W (UNIT_W)
    ) u_haz (
        .old_dst_i  (s0_dst_i),
        .old_wen_i  (s0_wen_i),
        .old_unit_i (s0_unit_i),
        .yng_src_i  (yng_src),
        .yng_dst_i  (s1_dst_i),
        .yng_wen_i  (s1_wen_i),
        .yng_unit_i (s1_unit_i),
        .raw_o      (raw_hit),
        .waw_o      (waw_hit),
        .unit_o     (unit_hit)
    );

    assign pair_ok = s1_valid_i && yng_fits && !raw_hit && !waw_hit && !unit_hit;

    always_comb begin
        iss_d = '0;
        if (ready_i && s0_valid_i) begin
            iss_d.a   = 1'b1;
            iss_d.cnt = 2'd1;
            if (pair_ok) begin
                iss_d.b   = 1'b1;
                iss_d.cnt = 2'd2;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iss_q <= '0;
        end else begin
            iss_q <= iss_d;
        end
    end

    assign pipe_a_issue_o = iss_q.a;
    assign pipe_b_issue_o = iss_q.b;
    assign consumed_o     = iss_q.cnt;

    // R5
    b_needs_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_b_issue_o |-> pipe_a_issue_o);
    // R2
    stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ready_i) |-> (consumed_o == 2'd0));
    // R12
    no_old_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(s0_valid_i) |-> !pipe_a_issue_o);
    // R6
    b_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_b_issue_o |-> $past(yng_fits));
    // R7
    b_no_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_b_issue_o |-> !$past(raw_hit));
    // R8
    b_no_waw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_b_issue_o |-> !$past(waw_hit));
    // R10
    b_no_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_b_issue_o |-> !$past(unit_hit));
    // R4
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        consumed_o != 2'd3);

endmodule

// File: tb/sim_dual_issue_pair.sv
`timescale 1ns/1ps
module sim_dual_issue_pair;
    localparam int REG_W  = 5;
    localparam int UNIT_W = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ready_i = 1'b0;
    logic              s0_valid_i = 1'b0;
    logic [2:0]        s0_class_i = '0;
    logic [REG_W-1:0]  s0_dst_i = '0;
    logic              s0_wen_i = 1'b0;
    logic [UNIT_W-1:0] s0_unit_i = '0;
    logic              s1_valid_i = 1'b0;
    logic [2:0]        s1_class_i = '0;
    logic [REG_W-1:0]  s1_dst_i = '0;
    logic              s1_wen_i = 1'b0;
    logic [REG_W-1:0]  s1_src_a_i = '0;
    logic [REG_W-1:0]  s1_src_b_i = '0;
    logic [UNIT_W-1:0] s1_unit_i = '0;
    logic              pipe_a_issue_o;
    logic              pipe_b_issue_o;
    logic [1:0]        consumed_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dual_issue_pair #(.REG_W(REG_W), .UNIT_W(UNIT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .ready_i(ready_i),
        .s0_valid_i(s0_valid_i), .s0_class_i(s0_class_i), .s0_dst_i(s0_dst_i),
        .s0_wen_i(s0_wen_i), .s0_unit_i(s0_unit_i),
        .s1_valid_i(s1_valid_i), .s1_class_i(s1_class_i), .s1_dst_i(s1_dst_i),
        .s1_wen_i(s1_wen_i), .s1_src_a_i(s1_src_a_i), .s1_src_b_i(s1_src_b_i),
        .s1_unit_i(s1_unit_i),
        .pipe_a_issue_o(pipe_a_issue_o), .pipe_b_issue_o(pipe_b_issue_o),
        .consumed_o(consumed_o)
    );

    task automatic check_out(input logic ea, input logic eb, input logic [1:0] ec,
                             input string req);
        checks++;
        if (pipe_a_issue_o !== ea || pipe_b_issue_o !== eb || consumed_o !== ec) begin
            failures++;
            $display("FAIL %s actual a=%b b=%b cnt=%0d expected a=%b b=%b cnt=%0d",
                     req, pipe_a_issue_o, pipe_b_issue_o, consumed_o, ea, eb, ec);
        end
    endtask

    task automatic step_check(input logic ea, input logic eb, input logic [1:0] ec,
                              input string req);
        @(posedge clk);
        #1;
        check_out(ea, eb, ec, req);
    endtask

    task automatic set_old(input logic v, input logic [2:0] c, input logic [REG_W-1:0] d,
                           input logic w, input logic [UNIT_W-1:0] u);
        s0_valid_i = v; s0_class_i = c; s0_dst_i = d; s0_wen_i = w; s0_unit_i = u;
    endtask

    task automatic set_yng(input logic v, input logic [2:0] c, input logic [REG_W-1:0] d,
                           input logic w, input logic [REG_W-1:0] sa,
                           input logic [REG_W-1:0] sb, input logic [UNIT_W-1:0] u);
        s1_valid_i = v; s1_class_i = c; s1_dst_i = d; s1_wen_i = w;
        s1_src_a_i = sa; s1_src_b_i = sb; s1_unit_i = u;
    endtask

    // Pairable baseline: independent registers, distinct tags
    task automatic base_pair();
        set_old(1'b1, 3'd0, 5'd3, 1'b1, 2'd1);
        set_yng(1'b1, 3'd0, 5'd4, 1'b1, 5'd5, 5'd6, 2'd2);
    endtask

    task automatic t_reset();
        ready_i = 1'b1;
        base_pair();
        repeat (2) @(posedge clk);
        #1;
        check_out(1'b0, 1'b0, 2'd0, "R1 reset");
        rst_n = 1'b1;
    endtask

    task automatic t_stall();
        base_pair();
        ready_i = 1'b0;
        step_check(1'b0, 1'b0, 2'd0, "R2 stall with pairable slots");
        ready_i = 1'b1;
        step_check(1'b1, 1'b1, 2'd2, "R5 same pair after stall");
    endtask

    task automatic t_pair_kinds();
        base_pair();
        s1_class_i = 3'd1;
        step_check(1'b1, 1'b1, 2'd2, "R5 younger move pairs");
        s0_class_i = 3'd5;
        step_check(1'b1, 1'b1, 2'd2, "R5 complex older with simple younger");
    endtask

    task automatic t_any_old_class();
        for (int c = 0; c < 8; c++) begin
            set_old(1'b1, 3'(c), 5'd7, 1'b1, 2'd0);
            set_yng(1'b0, 3'd0, 5'd8, 1'b0, 5'd1, 5'd2, 2'd0);
            step_check(1'b1, 1'b0, 2'd1, "R3 older of any class on pipe A");
        end
    endtask

    task automatic t_single();
        base_pair();
        s1_valid_i = 1'b0;
        step_check(1'b1, 1'b0, 2'd1, "R4 lone older entry");
    endtask

    task automatic t_class_veto();
        for (int c = 2; c < 8; c++) begin
            base_pair();
            s1_class_i = 3'(c);
            step_check(1'b1, 1'b0, 2'd1, "R6 younger class unfit for pipe B");
        end
    endtask

    task automatic t_raw();
        base_pair();
        s1_src_a_i = 5'd3;
        step_check(1'b1, 1'b0, 2'd1, "R7 RAW on first source");
        base_pair();
        s1_src_b_i = 5'd3;
        step_check(1'b1, 1'b0, 2'd1, "R7 RAW on second source");
        base_pair();
        s1_src_b_i = 5'd3;
        s1_unit_i = 2'd1;
        step_check(1'b1, 1'b0, 2'd1, "R7 RAW plus unit clash");
    endtask

    task automatic t_waw();
        base_pair();
        s1_dst_i = 5'd3;
        step_check(1'b1, 1'b0, 2'd1, "R8 same destination");
        base_pair();
        s1_dst_i = 5'd3;
        s1_wen_i = 1'b0;
        step_check(1'b1, 1'b1, 2'd2, "R8 younger not writing");
        base_pair();
        s1_dst_i = 5'd3;
        s1_class_i = 3'd3;
        step_check(1'b1, 1'b0, 2'd1, "R8 WAW plus class veto");
    endtask

    task automatic t_zero_reg();
        base_pair();
        s0_dst_i = 5'd0;
        s1_dst_i = 5'd0;
        s1_src_a_i = 5'd0;
        s1_src_b_i = 5'd0;
        step_check(1'b1, 1'b1, 2'd2, "R9 register zero never conflicts");
        base_pair();
        s0_wen_i = 1'b0;
        s1_src_a_i = 5'd3;
        step_check(1'b1, 1'b1, 2'd2, "R9 older not writing");
    endtask

    task automatic t_unit();
        base_pair();
        s0_unit_i = 2'd3;
        s1_unit_i = 2'd3;
        step_check(1'b1, 1'b0, 2'd1, "R10 shared unit tag");
        base_pair();
        s0_unit_i = 2'd0;
        s1_unit_i = 2'd0;
        step_check(1'b1, 1'b1, 2'd2, "R10 tag zero no clash");
    endtask

    task automatic t_old_invalid();
        base_pair();
        s0_valid_i = 1'b0;
        step_check(1'b0, 1'b0, 2'd0, "R12 older slot empty");
    endtask

    task automatic t_timing();
        base_pair();
        step_check(1'b1, 1'b1, 2'd2, "R11 pair registered");
        ready_i = 1'b0;
        s1_class_i = 3'd4;
        #1;
        check_out(1'b1, 1'b1, 2'd2, "R11 held between edges");
        step_check(1'b0, 1'b0, 2'd0, "R11 change seen at next edge");
        ready_i = 1'b1;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            failures++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_stall();
        t_pair_kinds();
        t_any_old_class();
        t_single();
        t_class_veto();
        t_raw();
        t_waw();
        t_zero_reg();
        t_unit();
        t_old_invalid();
        t_timing();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule